// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block turns one non-maskable interrupt pin and four external request pins into clean request outputs for a downstream priority stage. Every pin is resynchronized to the core clock. Each request line is then sensed either as an active-low level or as an edge. Edge-sensed requests are held in sticky pending flags until a per-line clear strobe arrives. The non-maskable line is always edge-sensed, with a programmable polarity, and is never masked here.

Two 16-bit registers on a simple single-cycle register bus set the sensing. A bus access is one cycle with `bus_sel` high. A write commits on that clock edge. A read returns data combinationally on `bus_rdata` for the address presented, with no wait state and no back-pressure. The sense-control register (address 0) holds the polarity and mode bits, and also reports the live synchronized level of the non-maskable pin. The edge-direction register (address 1) holds a 2-bit edge code for each request line.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, the sense-control register reads 0x8000 while the non-maskable pin is high, the edge-direction register reads 0x0000, all request lines are in level mode and no request is pending.
- R2: Bit 15 of the sense-control register returns the synchronized non-maskable pin level, 2 cycles after the pin changes. Writes to bit 15 have no effect.
- R3: Reserved bits read 0 whatever is written: bits 14..9 and 3..0 of the sense-control register, and bits 15..8 of the edge-direction register.
- R4: Sense-control bit 8 sets the non-maskable polarity (0 = falling edge, 1 = rising edge). A detected edge raises `nmi_req` 3 cycles after the pin change. It stays high until a cycle with `nmi_clr`, after which it is low on the next cycle. An edge of the other polarity is ignored.
- R5: In level mode (mode bit 0), `irq_req[i]` is high exactly while the synchronized pin is low. It follows the pin with 2 cycles of latency and is not latched.
- R6: In edge mode (mode bit 1), the edge-direction code for line i sets which edges are detected: 01 = falling, 10 = rising, 11 = both, 00 = none. A detected edge raises `irq_req[i]` 3 cycles after the pin change.
- R7: An edge-mode pending flag stays set until a cycle with `irq_clr[i]` high. It is cleared on the next cycle, and only for the lines whose clear bit is set.
- R8: A write that changes line i's mode bit clears that line's pending flag in the same cycle, so the mode change itself raises no request.
- R9: Mode bits sit at sense-control bits 7, 6, 5 and 4 for lines 0, 1, 2 and 3. Line i's edge code sits at edge-direction bits [2i+1:2i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | Access is a write |
| bus_addr | input | 1 | 0 = sense-control register, 1 = edge-direction register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| nmi_pin | input | 1 | Asynchronous non-maskable interrupt pin |
| irq_pin | input | 4 | Asynchronous request pins |
| nmi_clr | input | 1 | Clear strobe for the non-maskable pending flag |
| irq_clr | input | 4 | Per-line clear strobes for edge pending flags |
| nmi_req | output | 1 | Non-maskable request |
| irq_req | output | 4 | Request vector, one bit per line |

## Verification
A pin change is seen through two synchronizer flops. Level results and the read-back bit 15 are therefore due on the second clock edge after the change. Edge results need one more edge for the pending flag, so they are due on the third. Clear strobes and register writes take effect on the very next edge. The bench's driver queues each expected value with the exact cycle number at which it is due. It also queues checks one cycle early, which show that a result has not appeared before that cycle. The monitor compares each value two nanoseconds after the falling clock edge of its due cycle, well clear of any active edge.

// File: rtl/eis_pkg.sv
package eis_pkg;
  localparam int REG_W       = 16;
  localparam int LVL_BIT     = 15;
  localparam int NMI_POL_BIT = 8;
  localparam int MODE_MSB    = 7;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_RISE = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_code_e;
endpackage

// File: rtl/eis_sync.sv
module eis_sync #(
  parameter int W       = 5,
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= {W{RST_VAL}};
        else if (s == 0) chain[s] <= din;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/eis_line.sv
module eis_line (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp,
  input  logic       edge_mode,
  input  logic [1:0] edge_sel,
  input  logic       mode_chg,
  input  logic       clr,
  output logic       hit,
  output logic       req
);
  import eis_pkg::*;

  logic prev_q, pend_q, fall, rise;

  assign fall = prev_q & ~smp;
  assign rise = ~prev_q & smp;
  assign hit  = (edge_sel[0] & fall) | (edge_sel[1] & rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      prev_q <= smp;
      if (mode_chg || !edge_mode) pend_q <= 1'b0;
      else if (hit)               pend_q <= 1'b1;
      else if (clr)               pend_q <= 1'b0;
    end
  end

  assign req = edge_mode ? pend_q : ~smp;
endmodule

// File: rtl/eis_regs.sv
module eis_regs #(
  parameter int N = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_sel,
  input  logic                      bus_we,
  input  logic                      bus_addr,
  input  logic [eis_pkg::REG_W-1:0] bus_wdata,
  input  logic                      nmi_level,
  output logic [eis_pkg::REG_W-1:0] bus_rdata,
  output logic                      nmi_rise,
  output logic [N-1:0]              irq_mode,
  output logic [2*N-1:0]            irq_edge,
  output logic [N-1:0]              mode_chg
);
  import eis_pkg::*;

  logic wr_ctl, wr_edge;
  logic [N-1:0] new_mode;

  assign wr_ctl  = bus_sel & bus_we & ~bus_addr;
  assign wr_edge = bus_sel & bus_we &  bus_addr;

  generate
    for (genvar i = 0; i < N; i++) begin : g_mode
      assign new_mode[i] = bus_wdata[MODE_MSB-i];
      assign mode_chg[i] = wr_ctl & (new_mode[i] != irq_mode[i]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_rise <= 1'b0;
      irq_mode <= '0;
      irq_edge <= '0;
    end else begin
      if (wr_ctl) begin
        nmi_rise <= bus_wdata[NMI_POL_BIT];
        irq_mode <= new_mode;
      end
      if (wr_edge) irq_edge <= bus_wdata[2*N-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (!bus_addr) begin
      bus_rdata[LVL_BIT]     = nmi_level;
      bus_rdata[NMI_POL_BIT] = nmi_rise;
      for (int i = 0; i < N; i++) bus_rdata[MODE_MSB-i] = irq_mode[i];
    end else begin
      bus_rdata[2*N-1:0] = irq_edge;
    end
  end
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense #(
  parameter int N_IRQ       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic        bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        nmi_pin,
  input  logic [N_IRQ-1:0] irq_pin,
  input  logic        nmi_clr,
  input  logic [N_IRQ-1:0] irq_clr,
  output logic        nmi_req,
  output logic [N_IRQ-1:0] irq_req
);
  import eis_pkg::*;

  localparam int PINS = N_IRQ + 1;

  logic [PINS-1:0]    smp;
  logic               nmi_rise, nmi_hit;
  logic [N_IRQ-1:0]   irq_mode, mode_chg, irq_hit;
  logic [2*N_IRQ-1:0] irq_edge;
  logic [1:0]         nmi_sel;

  eis_sync #(.W(PINS), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({nmi_pin, irq_pin}), .dout(smp)
  );

  eis_regs #(.N(N_IRQ)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .nmi_level(smp[N_IRQ]),
    .bus_rdata(bus_rdata), .nmi_rise(nmi_rise), .irq_mode(irq_mode),
    .irq_edge(irq_edge), .mode_chg(mode_chg)
  );

  generate
    for (genvar i = 0; i < N_IRQ; i++) begin : g_line
      eis_line u_line (
        .clk(clk), .rst_n(rst_n), .smp(smp[i]), .edge_mode(irq_mode[i]),
        .edge_sel(irq_edge[2*i+1:2*i]), .mode_chg(mode_chg[i]),
        .clr(irq_clr[i]), .hit(irq_hit[i]), .req(irq_req[i])
      );
    end
  endgenerate

  assign nmi_sel = nmi_rise ? EDGE_RISE : EDGE_FALL;

  eis_line u_nmi (
    .clk(clk), .rst_n(rst_n), .smp(smp[N_IRQ]), .edge_mode(1'b1),
    .edge_sel(nmi_sel), .mode_chg(1'b0), .clr(nmi_clr),
    .hit(nmi_hit), .req(nmi_req)
  );
endmodule

// File: rtl/eis_chk.sv
module eis_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_sel,
  input logic         bus_we,
  input logic         bus_addr,
  input logic [15:0]  bus_rdata,
  input logic         nmi_pin,
  input logic [N-1:0] irq_pin,
  input logic         nmi_clr,
  input logic [N-1:0] irq_clr,
  input logic         nmi_req,
  input logic [N-1:0] irq_req,
  input logic [N-1:0] irq_mode,
  input logic [N-1:0] irq_hit,
  input logic         nmi_hit
);
  logic [1:0] age;
  logic       wr_ctl;

  assign wr_ctl = bus_sel & bus_we & ~bus_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R3: reserved bits read as zero
  p_rsv_ctl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_addr |-> (bus_rdata[14:9] == 6'd0 && bus_rdata[3:0] == 4'd0));
  p_rsv_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr |-> bus_rdata[15:8] == 8'd0);

  // R2: live level bit lags the pin by two edges
  p_level_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && !bus_addr) |-> bus_rdata[15] == $past(nmi_pin, 2));

  // R4: NMI pending holds until cleared, clears when no new edge
  p_nmi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req && !nmi_clr) |=> nmi_req);
  p_nmi_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_clr && !nmi_hit) |=> !nmi_req);

  generate
    for (genvar i = 0; i < N; i++) begin : g_chk
      // R5: level mode follows the pin two edges late
      p_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && !irq_mode[i]) |-> irq_req[i] == !$past(irq_pin[i], 2));
      // R6: a detected edge in edge mode raises the request next cycle
      p_edge_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mode[i] && irq_hit[i] && !wr_ctl) |=> irq_req[i]);
      // R7: pending is sticky without a clear or a mode write
      p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mode[i] && irq_req[i] && !irq_clr[i] && !wr_ctl) |=> irq_req[i]);
      // R8: entering edge mode starts with no pending request
      p_mode_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_mode[i]) |-> !irq_req[i]);
    end
  endgenerate
endmodule

bind ext_irq_sense eis_chk #(.N(N_IRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .nmi_pin(nmi_pin),
  .irq_pin(irq_pin), .nmi_clr(nmi_clr), .irq_clr(irq_clr),
  .nmi_req(nmi_req), .irq_req(irq_req), .irq_mode(irq_mode),
  .irq_hit(irq_hit), .nmi_hit(nmi_hit)
);

// File: tb/sim_ext_irq_sense.sv
`timescale 1ns/1ps
module sim_ext_irq_sense;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0, bus_addr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        nmi_pin = 1'b1;
  logic [3:0]  irq_pin = 4'hF;
  logic        nmi_clr = 1'b0;
  logic [3:0]  irq_clr = 4'h0;
  logic        nmi_req;
  logic [3:0]  irq_req;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  typedef struct {
    int          due;
    int          what;   // 0 irq_req, 1 nmi_req, 2 bus_rdata
    logic [15:0] exp;
    string       req;
  } item_t;
  item_t sb[$];

  ext_irq_sense u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .nmi_pin(nmi_pin), .irq_pin(irq_pin), .nmi_clr(nmi_clr),
    .irq_clr(irq_clr), .nmi_req(nmi_req), .irq_req(irq_req)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic expect_at(input int what, input logic [15:0] exp,
                           input int delay, input string req);
    item_t it;
    it.due = cyc + delay; it.what = what; it.exp = exp; it.req = req;
    sb.push_back(it);
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic a, input logic [15:0] exp, input string req);
    bus_addr = a;
    expect_at(2, exp, 0, req);
    tick();
  endtask

  // monitor: compare every item due by this cycle
  initial begin
    forever begin
      @(negedge clk);
      #2;
      for (int k = sb.size() - 1; k >= 0; k--) begin
        if (sb[k].due <= cyc) begin
          logic [15:0] act;
          case (sb[k].what)
            0:       act = {12'd0, irq_req};
            1:       act = {15'd0, nmi_req};
            default: act = bus_rdata;
          endcase
          checks++;
          if (act !== sb[k].exp) begin
            fails++;
            $display("FAIL %s: cycle %0d kind %0d actual %h expected %h",
                     sb[k].req, cyc, sb[k].what, act, sb[k].exp);
          end
          sb.delete(k);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    rd(1'b0, 16'h8000, "R1");
    rd(1'b1, 16'h0000, "R1");
    expect_at(0, 16'h0, 0, "R1");
    expect_at(1, 16'h0, 0, "R1");
    tick();
    // R5 level mode, latency and no latching
    irq_pin[2] = 1'b0;
    expect_at(0, 16'h0, 1, "R5 early");
    expect_at(0, 16'h4, 2, "R5");
    tick(3);
    irq_pin[2] = 1'b1;
    expect_at(0, 16'h0, 2, "R5 released");
    tick(3);
    // R4 falling edge default, R2 level read
    nmi_pin = 1'b0;
    expect_at(1, 16'h0, 2, "R4 early");
    expect_at(1, 16'h1, 3, "R4 falling");
    tick(2);
    rd(1'b0, 16'h0000, "R2");
    tick();
    expect_at(1, 16'h1, 0, "R4 sticky");
    wr(1'b0, 16'hFFFF);
    rd(1'b0, 16'h01F0, "R2 R3 write to level bit ignored");
    nmi_clr = 1'b1; tick(); nmi_clr = 1'b0;
    expect_at(1, 16'h0, 0, "R4 clear");
    nmi_pin = 1'b1;
    expect_at(1, 16'h1, 3, "R4 rising");
    tick(4);
    nmi_clr = 1'b1; tick(); nmi_clr = 1'b0;
    expect_at(1, 16'h0, 0, "R4 clear");
    nmi_pin = 1'b0;
    expect_at(1, 16'h0, 3, "R4 falling ignored");
    tick(4);
    // R9 edge codes: line0 01, line1 10, line2 11, line3 00
    wr(1'b1, 16'hFF39);
    rd(1'b1, 16'h0039, "R3 R9");
    // R6 falling edges
    irq_pin = 4'h0;
    expect_at(0, 16'h0, 2, "R6 early");
    expect_at(0, 16'h5, 3, "R6 falling");
    tick(4);
    irq_clr = 4'h5; tick(); irq_clr = 4'h0;
    expect_at(0, 16'h0, 0, "R7 clear");
    // R6 rising edges
    irq_pin = 4'hF;
    expect_at(0, 16'h6, 3, "R6 rising");
    tick(6);
    expect_at(0, 16'h6, 0, "R7 sticky");
    irq_clr = 4'h2; tick(); irq_clr = 4'h0;
    expect_at(0, 16'h4, 0, "R7 per line");
    tick();
    // R8 mode switches drop pending
    wr(1'b0, 16'h01D0);
    expect_at(0, 16'h0, 0, "R8 to level");
    tick();
    wr(1'b0, 16'h01F0);
    expect_at(0, 16'h0, 0, "R8 back to edge");
    tick();
    // R9 mode bit positions: only line0 edge
    wr(1'b0, 16'h0080);
    irq_pin = 4'h0;
    expect_at(0, 16'hE, 2, "R9 levels");
    expect_at(0, 16'hF, 3, "R9 edge line0");
    tick(4);
    rd(1'b0, 16'h0080, "R9");
    tick(2);
    wait (sb.size() == 0);
    tick();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule